// File: doc/BRIEF.md
# Accumulating Fractional Clock Divider

This block divides its input clock by a programmable ratio that does not have to be an integer. The ratio is an unsigned fixed-point number. A remainder register loses 1.0 on every enabled rising edge. On the edge where the remainder would fall below 1.0, the output flips and the ratio is added onto the leftover fraction. The fraction is never thrown away. Individual half-periods therefore alternate between the floor and the ceiling of the ratio, and their long-run average equals the ratio exactly.

Only rising edges are counted. The output frequency is therefore the input frequency divided by twice the ratio. A single-cycle strobe accompanies every flip of the output, so that surrounding logic can observe half-period boundaries. A ratio below 1.0 is treated as unusable: it parks the output low and freezes the count.

Top module: `frac_clk_div`

## Requirements
- R1: While rst_i is high, clk_o and reload_pulse_o are low and the remainder is loaded with ratio_i. After release, the first flip of clk_o comes after floor(ratio) counted edges.
- R2: ratio_i is unsigned with integer bits [15:8] and fraction bits [7:0]. Each rising edge with en_i high and a legal ratio is one counted event and lowers the remainder by exactly 1.0, leaving its fraction bits untouched.
- R3: When a counted event would leave the remainder below 1.0, clk_o flips and the ratio is added to what is left. After k flips from reset, exactly floor(k*ratio) events have been counted (for example, 2.5 gives half-periods 2,3,2,3).
- R4: A ratio of 3.25 gives half-periods of 3,3,3,4 counted events, repeating.
- R5: An integer ratio n gives every half-period exactly n events. With n = 1, clk_o flips on every edge.
- R6: reload_pulse_o is high for exactly the cycle in which clk_o shows a new value, and low whenever clk_o keeps its value.
- R7: While en_i is low and the ratio is legal, clk_o, the remainder and the half-period progress hold, and reload_pulse_o stays low.
- R8: A ratio below 1.0 (integer field zero) drives clk_o and reload_pulse_o low from the next edge and stops counting.
- R9: A new ratio is used only at the next reload. A half-period already running keeps the length set by the old value. For example, a change from 3.25 to 2.0 right after the first flip gives 3,3,2,2.
- R10: The largest ratio 0xFFFF counts without overflow and gives half-periods of 255 and then 256 events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; rising edges are the counted events |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| ratio_i | input | 16 | Division ratio, unsigned 8.8 fixed point |
| clk_o | output | 1 | Divided output |
| reload_pulse_o | output | 1 | One-cycle strobe on every flip of clk_o |

## Verification
The checker assumes that ratio_i is a steady level that is sampled on the clock, and that en_i changes only between edges. The bench drives both on the falling edge. After a reset with an illegal ratio, the remainder may hold a value below 1.0. The reload-value property therefore covers every remainder below 2.0, not only the remainders between 1.0 and 2.0. The stimulus keeps ratio_i constant inside each measured half-period sequence, except in the deliberate mid-period change and the switch to an illegal ratio. This keeps the bench's cumulative floor(k*ratio) expectation valid.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   localparam int DEF_INT_W  = 8;
   localparam int DEF_FRAC_W = 8;

   typedef struct packed {
      logic legal;
      logic count;
   } fdiv_gate_t;
endpackage

// File: rtl/fdiv_gate.sv
module fdiv_gate #(
   parameter int INT_W  = fdiv_pkg::DEF_INT_W,
   parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W,
   localparam int RW    = INT_W + FRAC_W
) (
   input  logic              en_i,
   input  logic [RW-1:0]     ratio_i,
   output fdiv_pkg::fdiv_gate_t gate_o
);
   logic legal;

   // a ratio is usable only when its integer field is non-zero
   assign legal        = |ratio_i[RW-1:FRAC_W];
   assign gate_o.legal = legal;
   assign gate_o.count = en_i & legal;
endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
   parameter int INT_W  = fdiv_pkg::DEF_INT_W,
   parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W,
   localparam int RW    = INT_W + FRAC_W,
   localparam int CNT_W = RW + 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             count_i,
   input  logic [RW-1:0]    ratio_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             reload_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1) << FRAC_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_val;
   logic             below_two;

   // one more decrement would leave less than 1.0
   assign below_two = (cnt_q[CNT_W-1:FRAC_W+1] == '0);
   assign reload_o  = count_i & below_two;

   generate
      if (FRAC_W > 0) begin : g_frac
         // leftover fraction carried into the next half-period
         assign reload_val = {{(INT_W+1){1'b0}}, cnt_q[FRAC_W-1:0]} + {1'b0, ratio_i};
      end else begin : g_int
         assign reload_val = {1'b0, ratio_i};
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= {1'b0, ratio_i};
      end else if (count_i) begin
         cnt_q <= below_two ? reload_val : cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/fdiv_toggle.sv
module fdiv_toggle (
   input  logic clk_i,
   input  logic rst_i,
   input  logic legal_i,
   input  logic reload_i,
   output logic out_o,
   output logic pulse_o
);
   logic out_q;
   logic pulse_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !legal_i) begin
         out_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= reload_i;
         if (reload_i) out_q <= ~out_q;
      end
   end

   assign out_o   = out_q;
   assign pulse_o = pulse_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
   parameter int INT_W  = fdiv_pkg::DEF_INT_W,
   parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W,
   localparam int RW    = INT_W + FRAC_W,
   localparam int CNT_W = RW + 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          en_i,
   input  logic [RW-1:0] ratio_i,
   output logic          clk_o,
   output logic          reload_pulse_o
);
   generate
      if (INT_W < 1) begin : g_bad_int
         $error("frac_clk_div: INT_W must be at least 1");
      end
      if (FRAC_W < 0) begin : g_bad_frac
         $error("frac_clk_div: FRAC_W must not be negative");
      end
   endgenerate

   fdiv_pkg::fdiv_gate_t gate;
   logic [CNT_W-1:0]     cnt_w;
   logic                 reload;

   fdiv_gate #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_gate (
      .en_i    (en_i),
      .ratio_i (ratio_i),
      .gate_o  (gate)
   );

   fdiv_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .count_i  (gate.count),
      .ratio_i  (ratio_i),
      .cnt_o    (cnt_w),
      .reload_o (reload)
   );

   fdiv_toggle u_toggle (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .legal_i  (gate.legal),
      .reload_i (reload),
      .out_o    (clk_o),
      .pulse_o  (reload_pulse_o)
   );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
   parameter int INT_W  = fdiv_pkg::DEF_INT_W,
   parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W,
   localparam int RW    = INT_W + FRAC_W,
   localparam int CNT_W = RW + 1
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [RW-1:0]    ratio,
   input logic             out,
   input logic             pulse,
   input logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1) << FRAC_W;
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2) << FRAC_W;

   logic legal;
   assign legal = |ratio[RW-1:FRAC_W];

   // R2
   step_down_chk: assert property (@(posedge clk) disable iff (rst)
      (en && legal && cnt >= TWO) |=> (cnt == $past(cnt) - ONE) && !pulse);

   // R3
   reload_add_chk: assert property (@(posedge clk) disable iff (rst)
      (en && legal && cnt < TWO) |=>
         (cnt == ($past(cnt) & (ONE - 1'b1)) + {1'b0, $past(ratio)}) && pulse);

   // R6
   pulse_flips_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |-> (out != $past(out)));

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!en && legal) |=> $stable(out) && $stable(cnt) && !pulse);

   // R8
   illegal_parks_chk: assert property (@(posedge clk) disable iff (rst)
      !legal |=> !out && !pulse && $stable(cnt));

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |-> (cnt >= ONE));
endmodule

bind frac_clk_div frac_clk_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
   .clk   (clk_i),
   .rst   (rst_i),
   .en    (en_i),
   .ratio (ratio_i),
   .out   (clk_o),
   .pulse (reload_pulse_o),
   .cnt   (cnt_w)
);

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic [15:0] ratio = 16'h0100;
   logic        clk_o;
   logic        pulse;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   frac_clk_div i_frac_clk_div (
      .clk_i          (clk),
      .rst_i          (rst),
      .en_i           (en),
      .ratio_i        (ratio),
      .clk_o          (clk_o),
      .reload_pulse_o (pulse)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // leaves the bench at a falling edge with reset released
   task automatic do_reset(input logic [15:0] r);
      @(negedge clk);
      rst = 1'b1; en = 1'b1; ratio = r;
      @(negedge clk);
      @(negedge clk);
      chk(clk_o == 1'b0, "R1 out low in reset", clk_o, 0);
      chk(pulse == 1'b0, "R1 pulse low in reset", pulse, 0);
      rst = 1'b0;
   endtask

   // cumulative events at the k-th flip must equal floor(k*ratio)
   task automatic expect_toggles(input logic [15:0] r, input int n, input int gap, input string tag);
      int   ev = 0;
      int   k = 0;
      int   cyc = 0;
      logic prev_out;
      do_reset(r);
      prev_out = clk_o;
      while (k < n && cyc < 5000) begin
         bit en_edge;
         en = (gap != 0 && (cyc % gap) == gap - 1) ? 1'b0 : 1'b1;
         en_edge = en;
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (en_edge) ev++;
         if (pulse) begin
            longint expv;
            k++;
            expv = (longint'(k) * longint'(r)) >> 8;
            chk(ev == expv, tag, ev, expv);
            chk(clk_o == ~prev_out, "R6 flip with pulse", clk_o, ~prev_out);
         end else begin
            chk(clk_o == prev_out, "R6 no flip without pulse", clk_o, prev_out);
         end
         if (!en_edge) chk(!pulse, "R7 no pulse while disabled", pulse, 0);
         prev_out = clk_o;
      end
      chk(k == n, {tag, " flip count"}, k, n);
      en = 1'b1;
   endtask

   task automatic test_illegal();
      do_reset(16'h0080);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(clk_o == 1'b0 && pulse == 1'b0, "R8 parked for ratio 0.5", {clk_o, pulse}, 0);
      end
      do_reset(16'h0340);
      for (int i = 0; i < 3; i++) @(negedge clk);
      chk(clk_o == 1'b1, "R1 first flip after 3 events", clk_o, 1);
      ratio = 16'h0000;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(clk_o == 1'b0 && pulse == 1'b0, "R8 parked for ratio 0", {clk_o, pulse}, 0);
      end
   endtask

   task automatic test_change();
      int exp_len[4] = '{3, 3, 2, 2};
      int len = 0;
      int k = 0;
      int cyc = 0;
      do_reset(16'h0340);
      while (k < 4 && cyc < 100) begin
         @(negedge clk);
         cyc++;
         len++;
         if (pulse) begin
            chk(len == exp_len[k], "R9 half-period after ratio change", len, exp_len[k]);
            if (k == 0) ratio = 16'h0200;
            k++;
            len = 0;
         end
      end
      chk(k == 4, "R9 flip count", k, 4);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      expect_toggles(16'h0340, 8, 0, "R4 ratio 3.25");
      expect_toggles(16'h0180, 6, 0, "R2 ratio 1.5");
      expect_toggles(16'h0280, 6, 0, "R3 ratio 2.5");
      expect_toggles(16'h0100, 8, 0, "R5 ratio 1");
      expect_toggles(16'h0300, 4, 0, "R5 ratio 3");
      expect_toggles(16'h0240, 6, 3, "R7 ratio 2.25 gated");
      expect_toggles(16'hFFFF, 2, 0, "R10 max ratio");
      test_illegal();
      test_change();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule